// File: doc/BRIEF.md
# Battery Thermistor Zone Classifier

This block sorts a digitized thermistor reading into one of six battery temperature zones. It then uses the zone to pick the termination-voltage code and the charge-current code that the charge controller applies. The reading is the thermistor divider ratio in steps of 0.1 % of the reference voltage, so 1000 is full scale. The ratio falls as the battery warms. A new reading is accepted only on a cycle where the sample strobe is high.

Each zone boundary has two crossing points. A hysteresis band of about one degree separates the inner boundaries, and about ten degrees separates the two outer limits. Two threshold tables are built in, one for each thermistor type, and a select input picks between them. The below-0 and above-60 zones raise a fault and block charging. Two more conditions also block charging: a reading near full scale, which means an open thermistor, and an invalid termination code for the present zone.

Top module: `thermal_zone_classifier`

## Requirements
- R1: After reset the zone is 2 (10–45 °C), no fault flag is set, and the codes shown are those of charging zone index 1.
- R2: The zone register changes only on a cycle with `sample_valid_i` high, and the new value is visible after that clock edge. Each accepted sample moves the zone by at most one step.
- R3: With `tbl_sel_i`=0, a sample warms the zone one step when the ratio is at or below these values: 665 (0→1), 654 (1→2), 345 (2→3), 308 (3→4) and 249 (4→5). Zone codes are 0 below 0 °C, 1 for 0–10, 2 for 10–45, 3 for 45–50, 4 for 50–60 and 5 above 60 °C.
- R4: With `tbl_sel_i`=0, a sample cools the zone one step when the ratio is at or above these values: 308 (5→4), 315 (4→3), 353 (3→2), 662 (2→1) and 756 (1→0). A reading between a warming point and its cooling point leaves the zone unchanged.
- R5: With `tbl_sel_i`=1, the warming points are 698, 686, 313, 270 and 194, and the cooling points are 270, 278, 323, 698 and 805, in the same order as in R3 and R4.
- R6: `cold_fault_o` is high exactly in zone 0, `hot_fault_o` is high exactly in zone 5, and either one forces `inhibit_o` high.
- R7: In charging zone z (1 to 4), `term_code_o` is `term_cfg_i[3*(z-1) +: 3]` and `curr_code_o` is `curr_cfg_i[4*(z-1) +: 4]`. In zones 0 and 5 both codes are 0.
- R8: If the selected termination code is 3'b111, `inhibit_o` is high while both fault flags stay low.
- R9: A sample with ratio ≥ 990 sets `open_fault_o`, forces `inhibit_o` high and leaves the zone unchanged. The next accepted sample below 990 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe that marks a new ratio sample |
| ratio_i | input | 10 | Thermistor ratio in 0.1 % steps |
| tbl_sel_i | input | 1 | Threshold table: 0 = 10 kΩ, 1 = 100 kΩ |
| term_cfg_i | input | 12 | Four 3-bit termination codes, one per charging zone |
| curr_cfg_i | input | 16 | Four 4-bit current codes, one per charging zone |
| zone_o | output | 3 | Present zone, 0 to 5 |
| term_code_o | output | 3 | Termination code for the present zone |
| curr_code_o | output | 4 | Current code for the present zone |
| inhibit_o | output | 1 | Charging blocked |
| cold_fault_o | output | 1 | Below 0 °C fault |
| hot_fault_o | output | 1 | Above 60 °C fault |
| open_fault_o | output | 1 | Open thermistor fault |

## Verification
The bench builds the block with its default parameters: four charging zones, 3-bit termination codes, 4-bit current codes and an open limit of 990. With these values every threshold of both tables falls inside the 10-bit ratio range. The vector walk steps each boundary one count inside and one count outside its hysteresis band, in both directions and for both tables. It also feeds extreme ratios that would jump several zones, to show that the zone still moves only one step per sample. Directed tests then cover the idle strobe, an open-thermistor sample, an invalid termination code and a reset in mid-run.

// File: rtl/tz_pkg.sv
package tz_pkg;

  localparam int RATIO_W = 10;
  localparam int ZONE_W  = 3;

  typedef enum logic [ZONE_W-1:0] {
    ZN_FREEZE   = 3'd0,
    ZN_COOL     = 3'd1,
    ZN_MILD     = 3'd2,
    ZN_WARM     = 3'd3,
    ZN_HOT      = 3'd4,
    ZN_OVERHEAT = 3'd5
  } zone_e;

  // warm_* : ratio at or below moves one zone hotter
  // cool_* : ratio at or above moves one zone colder
  typedef struct packed {
    logic [RATIO_W-1:0] warm_0;
    logic [RATIO_W-1:0] cool_0;
    logic [RATIO_W-1:0] warm_10;
    logic [RATIO_W-1:0] cool_10;
    logic [RATIO_W-1:0] warm_45;
    logic [RATIO_W-1:0] cool_45;
    logic [RATIO_W-1:0] warm_50;
    logic [RATIO_W-1:0] cool_50;
    logic [RATIO_W-1:0] warm_60;
    logic [RATIO_W-1:0] cool_60;
  } tz_thr_t;

  localparam tz_thr_t THR_LO_R = '{
    warm_0:  10'd665, cool_0:  10'd756,
    warm_10: 10'd654, cool_10: 10'd662,
    warm_45: 10'd345, cool_45: 10'd353,
    warm_50: 10'd308, cool_50: 10'd315,
    warm_60: 10'd249, cool_60: 10'd308
  };

  localparam tz_thr_t THR_HI_R = '{
    warm_0:  10'd698, cool_0:  10'd805,
    warm_10: 10'd686, cool_10: 10'd698,
    warm_45: 10'd313, cool_45: 10'd323,
    warm_50: 10'd270, cool_50: 10'd278,
    warm_60: 10'd194, cool_60: 10'd270
  };

endpackage

// File: rtl/tz_thr_sel.sv
module tz_thr_sel
  import tz_pkg::*;
(
  input  logic    sel_i,
  output tz_thr_t thr_o
);
  always_comb thr_o = sel_i ? THR_HI_R : THR_LO_R;
endmodule

// File: rtl/tz_zone_step.sv
module tz_zone_step
  import tz_pkg::*;
(
  input  zone_e              zone_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  tz_thr_t            thr_i,
  output zone_e              zone_nx_o
);
  // one boundary per evaluation; cooling point checked first
  always_comb begin
    zone_nx_o = zone_i;
    case (zone_i)
      ZN_FREEZE: begin
        if (ratio_i <= thr_i.warm_0) zone_nx_o = ZN_COOL;
      end
      ZN_COOL: begin
        if (ratio_i >= thr_i.cool_0)       zone_nx_o = ZN_FREEZE;
        else if (ratio_i <= thr_i.warm_10) zone_nx_o = ZN_MILD;
      end
      ZN_MILD: begin
        if (ratio_i >= thr_i.cool_10)      zone_nx_o = ZN_COOL;
        else if (ratio_i <= thr_i.warm_45) zone_nx_o = ZN_WARM;
      end
      ZN_WARM: begin
        if (ratio_i >= thr_i.cool_45)      zone_nx_o = ZN_MILD;
        else if (ratio_i <= thr_i.warm_50) zone_nx_o = ZN_HOT;
      end
      ZN_HOT: begin
        if (ratio_i >= thr_i.cool_50)      zone_nx_o = ZN_WARM;
        else if (ratio_i <= thr_i.warm_60) zone_nx_o = ZN_OVERHEAT;
      end
      ZN_OVERHEAT: begin
        if (ratio_i >= thr_i.cool_60) zone_nx_o = ZN_HOT;
      end
      default: zone_nx_o = ZN_MILD;
    endcase
  end
endmodule

// File: rtl/tz_code_sel.sv
module tz_code_sel
  import tz_pkg::*;
#(
  parameter int N_CHG  = 4,
  parameter int TERM_W = 3,
  parameter int CURR_W = 4
) (
  input  zone_e                      zone_i,
  input  logic [N_CHG*TERM_W-1:0]    term_cfg_i,
  input  logic [N_CHG*CURR_W-1:0]    curr_cfg_i,
  output logic [TERM_W-1:0]          term_o,
  output logic [CURR_W-1:0]          curr_o,
  output logic                       term_bad_o
);
  logic [TERM_W-1:0] term_tab [N_CHG];
  logic [CURR_W-1:0] curr_tab [N_CHG];

  for (genvar k = 0; k < N_CHG; k++) begin : g_unpack
    assign term_tab[k] = term_cfg_i[k*TERM_W +: TERM_W];
    assign curr_tab[k] = curr_cfg_i[k*CURR_W +: CURR_W];
  end

  // charging zone k+1 uses slot k; non-charging zones give zero codes
  always_comb begin
    term_o = '0;
    curr_o = '0;
    for (int k = 0; k < N_CHG; k++) begin
      if (zone_i == zone_e'(k + 1)) begin
        term_o = term_tab[k];
        curr_o = curr_tab[k];
      end
    end
  end

  assign term_bad_o = &term_o;
endmodule

// File: rtl/thermal_zone_classifier.sv
module thermal_zone_classifier
  import tz_pkg::*;
#(
  parameter int N_CHG    = 4,
  parameter int TERM_W   = 3,
  parameter int CURR_W   = 4,
  parameter int OPEN_LIM = 990
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_valid_i,
  input  logic [RATIO_W-1:0]      ratio_i,
  input  logic                    tbl_sel_i,
  input  logic [N_CHG*TERM_W-1:0] term_cfg_i,
  input  logic [N_CHG*CURR_W-1:0] curr_cfg_i,
  output logic [ZONE_W-1:0]       zone_o,
  output logic [TERM_W-1:0]       term_code_o,
  output logic [CURR_W-1:0]       curr_code_o,
  output logic                    inhibit_o,
  output logic                    cold_fault_o,
  output logic                    hot_fault_o,
  output logic                    open_fault_o
);
  localparam logic [RATIO_W-1:0] OPEN_R = RATIO_W'(OPEN_LIM);

  tz_thr_t thr;
  zone_e   zone_q, zone_nx;
  logic    open_q, open_now, term_bad;

  tz_thr_sel u_thr (
    .sel_i (tbl_sel_i),
    .thr_o (thr)
  );

  tz_zone_step u_step (
    .zone_i    (zone_q),
    .ratio_i   (ratio_i),
    .thr_i     (thr),
    .zone_nx_o (zone_nx)
  );

  assign open_now = (ratio_i >= OPEN_R);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zone_q <= ZN_MILD;
      open_q <= 1'b0;
    end else if (sample_valid_i) begin
      open_q <= open_now;
      if (!open_now) zone_q <= zone_nx;
    end
  end

  tz_code_sel #(
    .N_CHG  (N_CHG),
    .TERM_W (TERM_W),
    .CURR_W (CURR_W)
  ) u_codes (
    .zone_i     (zone_q),
    .term_cfg_i (term_cfg_i),
    .curr_cfg_i (curr_cfg_i),
    .term_o     (term_code_o),
    .curr_o     (curr_code_o),
    .term_bad_o (term_bad)
  );

  assign zone_o       = zone_q;
  assign cold_fault_o = (zone_q == ZN_FREEZE);
  assign hot_fault_o  = (zone_q == ZN_OVERHEAT);
  assign open_fault_o = open_q;
  assign inhibit_o    = cold_fault_o | hot_fault_o | open_q | term_bad;
endmodule

// File: rtl/tz_checker.sv
module tz_checker #(
  parameter int TERM_W   = 3,
  parameter int OPEN_LIM = 990
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic [9:0]        ratio_i,
  input logic [2:0]        zone_o,
  input logic [TERM_W-1:0] term_code_o,
  input logic              inhibit_o,
  input logic              cold_fault_o,
  input logic              hot_fault_o,
  input logic              open_fault_o
);
  p_reset_zone_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> zone_o == 3'd2);

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(zone_o));

  p_one_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, zone_o} == {1'b0, $past(zone_o)}) ||
             ({1'b0, zone_o} == {1'b0, $past(zone_o)} + 4'd1) ||
             ({1'b0, zone_o} + 4'd1 == {1'b0, $past(zone_o)}));

  p_fault_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cold_fault_o, hot_fault_o}));

  p_fault_inhibit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cold_fault_o || hot_fault_o) |-> inhibit_o);

  p_fault_codes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cold_fault_o || hot_fault_o) |-> term_code_o == '0);

  p_bad_term_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&term_code_o) |-> inhibit_o);

  p_open_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && ratio_i >= 10'(OPEN_LIM)) |=> ($stable(zone_o) && open_fault_o));

  p_open_inhibit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_fault_o |-> inhibit_o);
endmodule

bind thermal_zone_classifier tz_checker #(
  .TERM_W   (TERM_W),
  .OPEN_LIM (OPEN_LIM)
) u_tz_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .ratio_i        (ratio_i),
  .zone_o         (zone_o),
  .term_code_o    (term_code_o),
  .inhibit_o      (inhibit_o),
  .cold_fault_o   (cold_fault_o),
  .hot_fault_o    (hot_fault_o),
  .open_fault_o   (open_fault_o)
);

// File: tb/tb_thermal_zone_classifier.sv
module tb_thermal_zone_classifier;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [9:0]  ratio = 10'd500;
  logic        tsel = 1'b0;
  logic [11:0] term_cfg = {3'd6, 3'd4, 3'd2, 3'd1};
  logic [15:0] curr_cfg = {4'd1, 4'd8, 4'd15, 4'd3};
  logic [2:0]  zone;
  logic [2:0]  term;
  logic [3:0]  curr;
  logic        inh, cold, hot, opn;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_zone_classifier dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sample_valid_i (valid),
    .ratio_i        (ratio),
    .tbl_sel_i      (tsel),
    .term_cfg_i     (term_cfg),
    .curr_cfg_i     (curr_cfg),
    .zone_o         (zone),
    .term_code_o    (term),
    .curr_code_o    (curr),
    .inhibit_o      (inh),
    .cold_fault_o   (cold),
    .hot_fault_o    (hot),
    .open_fault_o   (opn)
  );

  // {table, ratio, expected zone}
  localparam int NV = 49;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 10'd500, 3'd2}, {1'b0, 10'd661, 3'd2}, {1'b0, 10'd662, 3'd1},
    {1'b0, 10'd655, 3'd1}, {1'b0, 10'd754, 3'd1}, {1'b0, 10'd756, 3'd0},
    {1'b0, 10'd700, 3'd0}, {1'b0, 10'd666, 3'd0}, {1'b0, 10'd665, 3'd1},
    {1'b0, 10'd654, 3'd2}, {1'b0, 10'd346, 3'd2}, {1'b0, 10'd345, 3'd3},
    {1'b0, 10'd352, 3'd3}, {1'b0, 10'd353, 3'd2}, {1'b0, 10'd345, 3'd3},
    {1'b0, 10'd309, 3'd3}, {1'b0, 10'd308, 3'd4}, {1'b0, 10'd314, 3'd4},
    {1'b0, 10'd250, 3'd4}, {1'b0, 10'd249, 3'd5}, {1'b0, 10'd307, 3'd5},
    {1'b0, 10'd308, 3'd4}, {1'b0, 10'd100, 3'd5}, {1'b0, 10'd800, 3'd4},
    {1'b0, 10'd800, 3'd3}, {1'b0, 10'd800, 3'd2}, {1'b0, 10'd800, 3'd1},
    {1'b0, 10'd800, 3'd0},
    {1'b1, 10'd700, 3'd0}, {1'b1, 10'd698, 3'd1}, {1'b1, 10'd804, 3'd1},
    {1'b1, 10'd805, 3'd0}, {1'b1, 10'd698, 3'd1}, {1'b1, 10'd687, 3'd1},
    {1'b1, 10'd686, 3'd2}, {1'b1, 10'd314, 3'd2}, {1'b1, 10'd313, 3'd3},
    {1'b1, 10'd271, 3'd3}, {1'b1, 10'd270, 3'd4}, {1'b1, 10'd195, 3'd4},
    {1'b1, 10'd194, 3'd5}, {1'b1, 10'd269, 3'd5}, {1'b1, 10'd270, 3'd4},
    {1'b1, 10'd277, 3'd4}, {1'b1, 10'd278, 3'd3}, {1'b1, 10'd322, 3'd3},
    {1'b1, 10'd323, 3'd2}, {1'b1, 10'd697, 3'd2}, {1'b1, 10'd698, 3'd1}
  };

  function automatic logic [2:0] exp_term(input logic [2:0] z);
    if (z >= 3'd1 && z <= 3'd4) return term_cfg[3*(z-1) +: 3];
    return 3'd0;
  endfunction

  function automatic logic [3:0] exp_curr(input logic [2:0] z);
    if (z >= 3'd1 && z <= 3'd4) return curr_cfg[4*(z-1) +: 4];
    return 4'd0;
  endfunction

  task automatic check(input string tag, input logic [2:0] ez, input logic eo);
    logic [2:0] et;
    logic [3:0] ec;
    logic ei, ecold, ehot;
    et = exp_term(ez);
    ec = exp_curr(ez);
    ecold = (ez == 3'd0);
    ehot  = (ez == 3'd5);
    ei = ecold | ehot | eo | (et == 3'd7);
    n_chk++;
    if (zone !== ez || term !== et || curr !== ec || inh !== ei ||
        cold !== ecold || hot !== ehot || opn !== eo) begin
      n_fail++;
      $display("FAIL %s: zone/term/curr/inh/cold/hot/open actual %0d/%0d/%0d/%0b/%0b/%0b/%0b expected %0d/%0d/%0d/%0b/%0b/%0b/%0b",
               tag, zone, term, curr, inh, cold, hot, opn, ez, et, ec, ei, ecold, ehot, eo);
    end
  endtask

  task automatic sample(input logic s, input logic [9:0] r);
    @(negedge clk);
    tsel  = s;
    ratio = r;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset state", 3'd2, 1'b0);

    // R3 R4 R5 R6 R7 boundary walk, R2 single step on extreme ratios
    for (int i = 0; i < NV; i++) begin
      sample(VEC[i][13], VEC[i][12:3]);
      check(VEC[i][13] ? "R5 R6 R7 R2 table" : "R3 R4 R6 R7 R2 table", VEC[i][2:0], 1'b0);
    end

    // R2: no strobe, zone holds
    ratio = 10'd100;
    repeat (5) @(negedge clk);
    check("R2 idle strobe", 3'd1, 1'b0);

    // R9 open thermistor
    sample(1'b1, 10'd995);
    check("R9 open set", 3'd1, 1'b1);
    sample(1'b1, 10'd990);
    check("R9 open at limit", 3'd1, 1'b1);
    sample(1'b1, 10'd600);
    check("R9 open cleared", 3'd2, 1'b0);

    // R8 invalid termination code in zone 2
    term_cfg = {3'd6, 3'd4, 3'd7, 3'd1};
    #1;
    check("R8 invalid term", 3'd2, 1'b0);
    sample(1'b1, 10'd698);
    check("R8 valid in zone 1", 3'd1, 1'b0);
    term_cfg = {3'd6, 3'd4, 3'd2, 3'd1};

    // R1 reset in mid-run
    sample(1'b1, 10'd805);
    check("R6 cold before reset", 3'd0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 async reset", 3'd2, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", 3'd2, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule